// File: doc/BRIEF.md
# Rotating-Parity Stripe Writer

This block sits between a host and an array of five independent block stores. It takes a logical block number and one block of new data, works out which store and which row hold that data block, and works out which store holds the parity for the same stripe. It then carries out the small-write update. It fetches the old data block and the old parity block, and combines them with the new data by XOR. It writes back the new data and the new parity. The other stores are left alone.

Each stripe is one row across all stores. The stripe holds four data blocks and one parity block. The parity block moves one store to the left on every new stripe. The host issues one command at a time. `cmd_busy` covers the whole update, and `cmd_done` pulses once when the update is finished.

The controller is a three-state machine:
- `ST_IDLE`: waits for a start.
- `ST_READ`: both reads are outstanding.
- `ST_WRITE`: both writes are outstanding.

It has three transitions:
- Start accept: `ST_IDLE` to `ST_READ`, on `cmd_start`.
- Reads complete: `ST_READ` to `ST_WRITE`, once both old values are held.
- Writes complete: `ST_WRITE` to `ST_IDLE`, once both writes are acknowledged. The `cmd_done` pulse is raised on this transition.

Top module: `parity_stripe_writer`

## Requirements
- R1: For logical block L, the stripe row is L/4 and the position inside the stripe is L mod 4. The parity store for row s is 4 − (s mod 5), so row 0 uses store 4, row 4 uses store 0, and row 5 uses store 4 again.
- R2: The data store is the position, plus one when the position is at or above the parity store index. The data store and the parity store are never the same.
- R3: After any sequence of commands, every row's parity block equals the XOR of that row's four data blocks. The data block for L holds the last value written to L.
- R4: One command performs exactly two reads and two writes. The reads go to the data store and the parity store, and only those two stores are accessed.
- R5: No write request is issued until both read requests have been acknowledged. The two writes may be issued in the same cycle.
- R6: `cmd_busy` rises in the cycle after an accepted start and stays high until both writes are acknowledged. `cmd_done` is then high for exactly one cycle, with `cmd_busy` low.
- R7: A `cmd_start` while `cmd_busy` is high is ignored. It changes no stored block and starts no further command.
- R8: After reset, `cmd_busy`, `cmd_done` and every store request are low. All-zero stores are consistent parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse for a small write |
| cmd_lba | input | LBA_W | Logical block number |
| cmd_wdata | input | DATA_W | New data block |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| col_req | output | NCOL | Per-store request, held until ready |
| col_we | output | NCOL | Per-store write enable |
| col_row | output | NCOL×ROW_W | Per-store row address |
| col_wdata | output | NCOL×DATA_W | Per-store write data |
| col_rdata | input | NCOL×DATA_W | Per-store read data, valid with ready |
| col_ready | input | NCOL | Per-store acknowledge, one cycle per request |

## Verification
The assertions assume the following about each store:
- It raises ready only for a request that is pending.
- It raises ready for one cycle only.
- It returns read data in that same cycle.

The bench memories follow this rule. Each memory answers one cycle after it sees a request, and it never answers twice for the same request. The start-while-busy check relies on `cmd_start` being sampled only in the idle state. The bench therefore sends its stray start pulses while a command is still in the read or write phase.

// File: rtl/psw_pkg.sv
package psw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } psw_state_e;
endpackage

// File: rtl/psw_map.sv
module psw_map #(
    parameter int NCOL  = 5,
    parameter int ROW_W = 4,
    parameter int LBA_W = 6
) (
    input  logic [LBA_W-1:0]          lba,
    output logic [ROW_W-1:0]          row,
    output logic [$clog2(NCOL)-1:0]   dcol,
    output logic [$clog2(NCOL)-1:0]   pcol
);
    localparam int DPS    = NCOL - 1;
    localparam int CIDX_W = $clog2(NCOL);

    int unsigned stripe, pos, pc, dc;

    always_comb begin
        stripe = 32'(lba) / DPS;
        pos    = 32'(lba) % DPS;
        // parity walks left one store per row, wrapping at store 0 (R1)
        pc     = (NCOL - 1) - (stripe % NCOL);
        // data skips over the parity store (R2)
        dc     = (pos >= pc) ? pos + 1 : pos;
        row    = ROW_W'(stripe);
        pcol   = CIDX_W'(pc);
        dcol   = CIDX_W'(dc);
    end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
#(
    parameter int NCOL   = 5,
    parameter int ROW_W  = 4,
    parameter int DATA_W = 16,
    parameter int LBA_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_start,
    input  logic [LBA_W-1:0]              cmd_lba,
    input  logic [DATA_W-1:0]             cmd_wdata,
    output logic                          cmd_busy,
    output logic                          cmd_done,
    output logic [LBA_W-1:0]              lba_q,
    input  logic [ROW_W-1:0]              map_row,
    input  logic [$clog2(NCOL)-1:0]       map_dcol,
    input  logic [$clog2(NCOL)-1:0]       map_pcol,
    output logic [NCOL-1:0]               col_req,
    output logic [NCOL-1:0]               col_we,
    output logic [NCOL-1:0][ROW_W-1:0]    col_row,
    output logic [NCOL-1:0][DATA_W-1:0]   col_wdata,
    input  logic [NCOL-1:0][DATA_W-1:0]   col_rdata,
    input  logic [NCOL-1:0]               col_ready
);
    psw_state_e state, state_nx;

    logic [DATA_W-1:0] wdata_q, old_d, old_p, par_new;
    logic              got_d, got_p;
    logic              rdy_d, rdy_p, pair_done;

    assign rdy_d     = col_ready[map_dcol];
    assign rdy_p     = col_ready[map_pcol];
    assign pair_done = (got_d | rdy_d) & (got_p | rdy_p);
    assign par_new   = old_p ^ old_d ^ wdata_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_start) state_nx = ST_READ;
            ST_READ:  if (pair_done) state_nx = ST_WRITE;
            ST_WRITE: if (pair_done) state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command latch, captured reads, acknowledge flags, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_q    <= '0;
            wdata_q  <= '0;
            old_d    <= '0;
            old_p    <= '0;
            got_d    <= 1'b0;
            got_p    <= 1'b0;
            cmd_done <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        lba_q   <= cmd_lba;
                        wdata_q <= cmd_wdata;
                        got_d   <= 1'b0;
                        got_p   <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (rdy_d && !got_d) begin
                        old_d <= col_rdata[map_dcol];
                        got_d <= 1'b1;
                    end
                    if (rdy_p && !got_p) begin
                        old_p <= col_rdata[map_pcol];
                        got_p <= 1'b1;
                    end
                    if (pair_done) begin
                        got_d <= 1'b0;
                        got_p <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    if (rdy_d) got_d <= 1'b1;
                    if (rdy_p) got_p <= 1'b1;
                    if (pair_done) begin
                        got_d    <= 1'b0;
                        got_p    <= 1'b0;
                        cmd_done <= 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs to the stores
    always_comb begin
        col_req   = '0;
        col_we    = '0;
        col_wdata = '0;
        cmd_busy  = (state != ST_IDLE);
        for (int c = 0; c < NCOL; c++) col_row[c] = map_row;
        unique case (state)
            ST_IDLE: ;
            ST_READ: begin
                if (!got_d) col_req[map_dcol] = 1'b1;
                if (!got_p) col_req[map_pcol] = 1'b1;
            end
            ST_WRITE: begin
                if (!got_d) begin
                    col_req[map_dcol]   = 1'b1;
                    col_we[map_dcol]    = 1'b1;
                end
                if (!got_p) begin
                    col_req[map_pcol]   = 1'b1;
                    col_we[map_pcol]    = 1'b1;
                end
                col_wdata[map_dcol] = wdata_q;
                col_wdata[map_pcol] = par_new;
            end
        endcase
    end

    assert_cols_differ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> (map_dcol != map_pcol));

    assert_two_stores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_req) <= 2);

    assert_reads_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|(col_req & col_we)) |-> $past(|(col_req & ~col_we)));

    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!cmd_busy && $past(cmd_busy)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && cmd_start) |=> ($stable(lba_q) && $stable(wdata_q)));
endmodule

// File: rtl/parity_stripe_writer.sv
module parity_stripe_writer #(
    parameter int NCOL   = 5,
    parameter int ROW_W  = 4,
    parameter int DATA_W = 16,
    parameter int LBA_W  = ROW_W + $clog2(NCOL - 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_start,
    input  logic [LBA_W-1:0]              cmd_lba,
    input  logic [DATA_W-1:0]             cmd_wdata,
    output logic                          cmd_busy,
    output logic                          cmd_done,
    output logic [NCOL-1:0]               col_req,
    output logic [NCOL-1:0]               col_we,
    output logic [NCOL-1:0][ROW_W-1:0]    col_row,
    output logic [NCOL-1:0][DATA_W-1:0]   col_wdata,
    input  logic [NCOL-1:0][DATA_W-1:0]   col_rdata,
    input  logic [NCOL-1:0]               col_ready
);
    localparam int CIDX_W = $clog2(NCOL);

    logic [LBA_W-1:0]  lba_q;
    logic [ROW_W-1:0]  map_row;
    logic [CIDX_W-1:0] map_dcol, map_pcol;

    psw_map #(.NCOL(NCOL), .ROW_W(ROW_W), .LBA_W(LBA_W)) u_map (
        .lba  (lba_q),
        .row  (map_row),
        .dcol (map_dcol),
        .pcol (map_pcol)
    );

    psw_ctrl #(.NCOL(NCOL), .ROW_W(ROW_W), .DATA_W(DATA_W), .LBA_W(LBA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_lba   (cmd_lba),
        .cmd_wdata (cmd_wdata),
        .cmd_busy  (cmd_busy),
        .cmd_done  (cmd_done),
        .lba_q     (lba_q),
        .map_row   (map_row),
        .map_dcol  (map_dcol),
        .map_pcol  (map_pcol),
        .col_req   (col_req),
        .col_we    (col_we),
        .col_row   (col_row),
        .col_wdata (col_wdata),
        .col_rdata (col_rdata),
        .col_ready (col_ready)
    );
endmodule

// File: tb/parity_stripe_writer_bench.sv
module parity_stripe_writer_bench;
    localparam int NCOL   = 5;
    localparam int ROW_W  = 4;
    localparam int DATA_W = 16;
    localparam int LBA_W  = ROW_W + 2;
    localparam int ROWS   = 1 << ROW_W;
    localparam int NLBA   = ROWS * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [LBA_W-1:0] cmd_lba = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic cmd_busy, cmd_done;
    logic [NCOL-1:0] col_req, col_we, col_ready;
    logic [NCOL-1:0][ROW_W-1:0] col_row;
    logic [NCOL-1:0][DATA_W-1:0] col_wdata, col_rdata;

    always #10 clk = ~clk;

    parity_stripe_writer #(.NCOL(NCOL), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_parity_stripe_writer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_lba(cmd_lba),
        .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .col_req(col_req), .col_we(col_we), .col_row(col_row),
        .col_wdata(col_wdata), .col_rdata(col_rdata), .col_ready(col_ready)
    );

    // block stores plus access monitor
    logic [DATA_W-1:0] mem [NCOL][ROWS];
    logic [NCOL-1:0] touched;
    int rd_cnt, wr_cnt;
    logic order_bad;
    logic clr_mon = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_ready <= '0;
            col_rdata <= '0;
            for (int c = 0; c < NCOL; c++)
                for (int r = 0; r < ROWS; r++) mem[c][r] <= '0;
        end else begin
            for (int c = 0; c < NCOL; c++) begin
                col_ready[c] <= col_req[c] & ~col_ready[c];
                if (col_req[c] && !col_ready[c]) begin
                    col_rdata[c] <= mem[c][col_row[c]];
                    if (col_we[c]) mem[c][col_row[c]] <= col_wdata[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_mon) begin
            touched <= '0; rd_cnt <= 0; wr_cnt <= 0; order_bad <= 1'b0;
        end else begin
            int nr, nw;
            nr = rd_cnt; nw = wr_cnt;
            for (int c = 0; c < NCOL; c++) begin
                if (col_req[c] && !col_ready[c]) begin
                    touched[c] <= 1'b1;
                    if (col_we[c]) begin
                        nw++;
                        if (rd_cnt < 2) order_bad <= 1'b1;
                    end else nr++;
                end
            end
            rd_cnt <= nr; wr_cnt <= nw;
        end
    end

    int checks = 0, fails = 0;
    logic [DATA_W-1:0] lval [NLBA];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pcol_of(input int s);
        return (NCOL - 1) - (s % NCOL);
    endfunction

    function automatic int dcol_of(input int l);
        int s, p;
        s = l / 4; p = l % 4;
        return (p >= pcol_of(s)) ? p + 1 : p;
    endfunction

    // compare every stored block with the image built from lval (R1 R2 R3)
    task automatic check_image();
        for (int s = 0; s < ROWS; s++) begin
            logic [DATA_W-1:0] px;
            px = '0;
            for (int p = 0; p < 4; p++) begin
                px ^= lval[s*4+p];
                chk(mem[dcol_of(s*4+p)][s] == lval[s*4+p], "R1/R2 data placement",
                    mem[dcol_of(s*4+p)][s], lval[s*4+p]);
            end
            chk(mem[pcol_of(s)][s] == px, "R3 parity", mem[pcol_of(s)][s], px);
        end
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 64 && !got; i++) begin
            @(negedge clk);
            if (cmd_done) got = 1'b1;
        end
    endtask

    task automatic do_write(input int l, input logic [DATA_W-1:0] v, input bit stray);
        bit got;
        int exp_mask;
        @(negedge clk);
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
        cmd_start = 1'b1; cmd_lba = LBA_W'(l); cmd_wdata = v;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(cmd_busy == 1'b1, "R6 busy after start", cmd_busy, 1);
        if (stray) begin
            // R7: a second start during the command
            cmd_start = 1'b1; cmd_lba = LBA_W'((l + 7) % NLBA); cmd_wdata = ~v;
            @(negedge clk);
            cmd_start = 1'b0;
            chk(cmd_busy == 1'b1, "R6 busy held", cmd_busy, 1);
        end
        wait_done(got);
        chk(got, "R6 done pulse", got, 1);
        chk(cmd_busy == 1'b0, "R6 busy low with done", cmd_busy, 0);
        @(negedge clk);
        chk(cmd_done == 1'b0, "R6 done one cycle", cmd_done, 0);
        chk(cmd_busy == 1'b0, "R7 no extra command", cmd_busy, 0);
        lval[l] = v;
        exp_mask = (1 << dcol_of(l)) | (1 << pcol_of(l / 4));
        chk(32'(touched) == exp_mask, "R4 stores touched", touched, exp_mask);
        chk(rd_cnt == 2 && wr_cnt == 2, "R4 two reads two writes", rd_cnt * 16 + wr_cnt, 34);
        chk(!order_bad, "R5 reads before writes", order_bad, 0);
        check_image();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLBA; i++) lval[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_busy == 1'b0, "R8 reset busy", cmd_busy, 0);
        chk(cmd_done == 1'b0, "R8 reset done", cmd_done, 0);
        chk(col_req == '0, "R8 reset requests", col_req, 0);
        check_image();
        // sweep every logical block, forward
        for (int l = 0; l < NLBA; l++)
            do_write(l, DATA_W'(l * 16'h3b1 + 16'h5a), 1'b0);
        // overwrite every block, reverse order, incremental parity (R3)
        for (int l = NLBA - 1; l >= 0; l--)
            do_write(l, DATA_W'(l * 16'h1c7 ^ 16'hc3e1), 1'b0);
        // repeated writes to one block, including zero and all-ones
        do_write(21, '0, 1'b0);
        do_write(21, '1, 1'b0);
        do_write(21, 16'h00ff, 1'b0);
        // stray starts while busy (R7), across several rows
        for (int l = 3; l < NLBA; l += 11)
            do_write(l, DATA_W'(16'h8001 + l), 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule